// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a serial test access port for a chip's boundary-scan logic. Four test pins drive it: a test clock, a mode-select line, a serial data input, and an optional asynchronous test reset. A sixteen-state controller follows the mode-select line on every rising edge of the test clock. It steers the serial stream into one of two places. The first is a 5-bit instruction register. The second is one of three data paths: a single-flop bypass stage, a 32-bit identification word, or an external boundary-scan chain.

The serial output and its enable change on the falling edge of the test clock. The output is driven only while a shift state is active.

The external chain is driven through four signals: a select, a capture strobe, a shift strobe and an update strobe. The chain returns its serial output through a dedicated input.

Three controls go to the core:
- A pin-drive mode, active while the external test instruction is loaded.
- A float request, active while the high-impedance instruction is loaded.
- A sticky test-mode flag. It is set by the external test instruction and cleared only by a separate device reset.

Every instruction code without a defined meaning falls back to bypass. A TDI line left open therefore selects bypass, and the core keeps running undisturbed.

Top module: `jtag_tap_port`

## Requirements
- R1: The controller follows the standard sixteen-state graph on rising TCK edges. This includes the pause and exit loops. Five consecutive edges with TMS high reach Test-Logic-Reset from any state.
- R2: Holding trst_n low forces Test-Logic-Reset asynchronously. In that state tdo_en is 0, and bsr_mode and out_float are 0. Whenever Test-Logic-Reset is reached, the active instruction becomes IDCODE (00010).
- R3: Capture-IR loads 5'b00001 into the instruction shifter. Shift-IR moves it out LSB first on TDO, and new bits enter from TDI at the MSB end.
- R4: Instruction decode works as follows:
  - 00000 (pin drive) and 00001 (sample/preload) select the external chain, so bsr_sel is 1.
  - 00010 selects the identification word.
  - 00011, 11111 and every code from 00100 to 11110 select the bypass flop.
- R5: The identification word is {VERSION[3:0], 16'h05D0, 11'h001, 1'b1}. It is loaded in Capture-DR and shifted out LSB first.
- R6: The bypass flop captures 0 in Capture-DR and delays TDI by one shift. While it is selected, the chain strobes stay low and the chain's updated contents are unchanged.
- R7: out_float is 1 exactly while 00011 is the active instruction.
- R8: bsr_mode is 1 exactly while 00000 is active. test_sticky becomes 1 once 00000 has been active. It then stays 1 across instruction changes and TAP resets, until dev_rst_n is driven low.
- R9: With 00001 or 00000 active, the chain strobes behave as follows:
  - bsr_capture is high in Capture-DR.
  - bsr_shift is high in Shift-DR.
  - bsr_update is high in Update-DR.
  - TDO carries bsr_tdo during Shift-DR.
  - Under 00001, bsr_mode stays 0.
- R10: tdo and tdo_en change only on falling TCK edges. tdo_en is 1 only in Shift-IR or Shift-DR. A newly shifted instruction becomes active on the falling edge in Update-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| dev_rst_n | input | 1 | Device reset, active low; clears the sticky flag |
| bsr_tdo | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | Output enable for tdo |
| bsr_sel | output | 1 | External chain is the selected data path |
| bsr_capture | output | 1 | Chain capture strobe (Capture-DR) |
| bsr_shift | output | 1 | Chain shift strobe (Shift-DR) |
| bsr_update | output | 1 | Chain update strobe (Update-DR) |
| bsr_mode | output | 1 | Pins driven from the chain |
| out_float | output | 1 | Float all outputs and bidirectional pins |
| test_sticky | output | 1 | Sticky test-mode flag |

## Verification
The bench builds the block with VERSION set to 4'hA, so a wrong order of the version nibble shows up in the identification readout. It also builds with HAS_TRST set to 1, which puts the asynchronous reset path within reach, including a reset in the middle of an operation. An 8-bit chain model sits on the strobes, so sample/preload capture and update can be checked, and the chain can be shown untouched under bypass. A pause inserted in the middle of a shift exercises the exit and pause loops of the controller.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

   localparam int IR_BITS = 5;
   localparam int ID_BITS = 32;

   typedef enum logic [3:0] {
      ST_RESET,
      ST_IDLE,
      ST_SEL_DR,
      ST_CAP_DR,
      ST_SH_DR,
      ST_EX1_DR,
      ST_PAU_DR,
      ST_EX2_DR,
      ST_UPD_DR,
      ST_SEL_IR,
      ST_CAP_IR,
      ST_SH_IR,
      ST_EX1_IR,
      ST_PAU_IR,
      ST_EX2_IR,
      ST_UPD_IR
   } tap_state_e;

   typedef logic [IR_BITS-1:0] ir_code_t;

   localparam ir_code_t OP_PINDRIVE = 5'b00000;
   localparam ir_code_t OP_SAMPLE   = 5'b00001;
   localparam ir_code_t OP_IDENT    = 5'b00010;
   localparam ir_code_t OP_FLOAT    = 5'b00011;
   localparam ir_code_t OP_BYPASS   = 5'b11111;

   localparam ir_code_t IR_CAPTURE_VAL = 5'b00001;

   typedef enum logic [1:0] {
      DR_BYPASS,
      DR_IDENT,
      DR_BOUNDARY
   } dr_sel_e;

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       rst_n,
   input  logic       tms,
   output tap_state_e state,
   output logic       in_reset,
   output logic       cap_ir,
   output logic       sh_ir,
   output logic       upd_ir,
   output logic       cap_dr,
   output logic       sh_dr,
   output logic       upd_dr
);

   tap_state_e nxt;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) state <= ST_RESET;
      else        state <= nxt;
   end

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
         ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
         default:   nxt = ST_RESET;
      endcase
   end

   assign in_reset = (state == ST_RESET);
   assign cap_ir   = (state == ST_CAP_IR);
   assign sh_ir    = (state == ST_SH_IR);
   assign upd_ir   = (state == ST_UPD_IR);
   assign cap_dr   = (state == ST_CAP_DR);
   assign sh_dr    = (state == ST_SH_DR);
   assign upd_dr   = (state == ST_UPD_DR);

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
   import tap_pkg::*;
(
   input  logic     tck,
   input  logic     rst_n,
   input  logic     tdi,
   input  logic     in_reset,
   input  logic     cap_ir,
   input  logic     sh_ir,
   input  logic     upd_ir,
   output ir_code_t ir_shift,
   output ir_code_t ir_active,
   output dr_sel_e  dr_sel,
   output logic     op_pindrive,
   output logic     op_float
);

   // shifter: capture a fixed pattern, then move toward bit 0
   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      ir_shift <= IR_CAPTURE_VAL;
      else if (cap_ir) ir_shift <= IR_CAPTURE_VAL;
      else if (sh_ir)  ir_shift <= {tdi, ir_shift[IR_BITS-1:1]};
   end

   // active instruction changes on the falling edge
   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)        ir_active <= OP_IDENT;
      else if (in_reset) ir_active <= OP_IDENT;
      else if (upd_ir)   ir_active <= ir_shift;
   end

   always_comb begin
      case (ir_active)
         OP_PINDRIVE, OP_SAMPLE: dr_sel = DR_BOUNDARY;
         OP_IDENT:               dr_sel = DR_IDENT;
         OP_FLOAT, OP_BYPASS:    dr_sel = DR_BYPASS;
         default:                dr_sel = DR_BYPASS;
      endcase
   end

   assign op_pindrive = (ir_active == OP_PINDRIVE);
   assign op_float    = (ir_active == OP_FLOAT);

endmodule

// File: rtl/tap_dr.sv
`timescale 1ns/1ps
module tap_dr
   import tap_pkg::*;
#(
   parameter logic [3:0]  VERSION  = 4'h0,
   parameter logic [15:0] PART_NUM = 16'h05D0,
   parameter logic [10:0] MFR_ID   = 11'h001
)(
   input  logic    tck,
   input  logic    rst_n,
   input  logic    tdi,
   input  logic    cap_dr,
   input  logic    sh_dr,
   input  logic    sh_ir,
   input  dr_sel_e dr_sel,
   input  logic    ir_lsb,
   input  logic    bsr_tdo,
   output logic    tdo,
   output logic    tdo_en
);

   localparam logic [ID_BITS-1:0] ID_WORD = {VERSION, PART_NUM, MFR_ID, 1'b1};

   logic               byp_q;
   logic [ID_BITS-1:0] id_q;
   logic               tdo_d;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)      byp_q <= 1'b0;
      else if (cap_dr) byp_q <= 1'b0;
      else if (sh_dr)  byp_q <= tdi;
   end

   for (genvar i = 0; i < ID_BITS; i++) begin : g_id
      logic feed;
      if (i == ID_BITS - 1) begin : g_top
         assign feed = tdi;
      end else begin : g_mid
         assign feed = id_q[i+1];
      end
      always_ff @(posedge tck or negedge rst_n) begin
         if (!rst_n)      id_q[i] <= ID_WORD[i];
         else if (cap_dr) id_q[i] <= ID_WORD[i];
         else if (sh_dr)  id_q[i] <= feed;
      end
   end

   always_comb begin
      tdo_d = tdo;
      if (sh_ir) begin
         tdo_d = ir_lsb;
      end else if (sh_dr) begin
         case (dr_sel)
            DR_BOUNDARY: tdo_d = bsr_tdo;
            DR_IDENT:    tdo_d = id_q[0];
            default:     tdo_d = byp_q;
         endcase
      end
   end

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo    <= tdo_d;
         tdo_en <= sh_ir | sh_dr;
      end
   end

endmodule

// File: rtl/jtag_tap_port.sv
`timescale 1ns/1ps
module jtag_tap_port
   import tap_pkg::*;
#(
   parameter logic [3:0]  VERSION  = 4'h0,
   parameter logic [15:0] PART_NUM = 16'h05D0,
   parameter logic [10:0] MFR_ID   = 11'h001,
   parameter bit          HAS_TRST = 1'b1
)(
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   input  logic tdi,
   input  logic dev_rst_n,
   input  logic bsr_tdo,
   output logic tdo,
   output logic tdo_en,
   output logic bsr_sel,
   output logic bsr_capture,
   output logic bsr_shift,
   output logic bsr_update,
   output logic bsr_mode,
   output logic out_float,
   output logic test_sticky
);

   if (MFR_ID == 11'h07F) begin : g_bad_mfr
      $error("MFR_ID 7F is reserved and cannot be used");
   end
   if (IR_BITS != 5) begin : g_bad_ir
      $error("instruction map assumes a 5-bit register");
   end

   logic tap_rst_n;
   if (HAS_TRST) begin : g_trst
      assign tap_rst_n = trst_n;
   end else begin : g_no_trst
      assign tap_rst_n = 1'b1;
   end

   tap_state_e fsm_state;
   logic       in_reset, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr;
   ir_code_t   ir_shift, ir_active;
   dr_sel_e    dr_sel;
   logic       op_pindrive, op_float;
   logic       sticky_q;

   tap_fsm u_fsm (
      .tck      (tck),
      .rst_n    (tap_rst_n),
      .tms      (tms),
      .state    (fsm_state),
      .in_reset (in_reset),
      .cap_ir   (cap_ir),
      .sh_ir    (sh_ir),
      .upd_ir   (upd_ir),
      .cap_dr   (cap_dr),
      .sh_dr    (sh_dr),
      .upd_dr   (upd_dr)
   );

   tap_ir u_ir (
      .tck         (tck),
      .rst_n       (tap_rst_n),
      .tdi         (tdi),
      .in_reset    (in_reset),
      .cap_ir      (cap_ir),
      .sh_ir       (sh_ir),
      .upd_ir      (upd_ir),
      .ir_shift    (ir_shift),
      .ir_active   (ir_active),
      .dr_sel      (dr_sel),
      .op_pindrive (op_pindrive),
      .op_float    (op_float)
   );

   tap_dr #(
      .VERSION  (VERSION),
      .PART_NUM (PART_NUM),
      .MFR_ID   (MFR_ID)
   ) u_dr (
      .tck     (tck),
      .rst_n   (tap_rst_n),
      .tdi     (tdi),
      .cap_dr  (cap_dr),
      .sh_dr   (sh_dr),
      .sh_ir   (sh_ir),
      .dr_sel  (dr_sel),
      .ir_lsb  (ir_shift[0]),
      .bsr_tdo (bsr_tdo),
      .tdo     (tdo),
      .tdo_en  (tdo_en)
   );

   assign bsr_sel     = (dr_sel == DR_BOUNDARY);
   assign bsr_capture = bsr_sel & cap_dr;
   assign bsr_shift   = bsr_sel & sh_dr;
   assign bsr_update  = bsr_sel & upd_dr;
   assign bsr_mode    = op_pindrive;
   assign out_float   = op_float;

   // sticky test flag: only the device reset clears it
   always_ff @(posedge tck or negedge dev_rst_n) begin
      if (!dev_rst_n)       sticky_q <= 1'b0;
      else if (op_pindrive) sticky_q <= 1'b1;
   end

   assign test_sticky = sticky_q | (op_pindrive & dev_rst_n);

endmodule

// File: rtl/jtag_tap_port_chk.sv
`timescale 1ns/1ps
module jtag_tap_port_chk
   import tap_pkg::*;
(
   input logic       tck,
   input logic       trst_n,
   input logic       dev_rst_n,
   input tap_state_e fsm_state,
   input ir_code_t   ir_active,
   input logic       tdo_en,
   input logic       out_float,
   input logic       bsr_mode,
   input logic       test_sticky,
   input logic       bsr_sel,
   input logic       bsr_capture,
   input logic       bsr_shift,
   input logic       bsr_update
);

   // R10: enable only seen while a shift state holds
   assert_tdo_en_R10: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en |-> (fsm_state == ST_SH_IR || fsm_state == ST_SH_DR));

   // R7: float and pin drive never together
   assert_float_excl_R7: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({out_float, bsr_mode}));

   // R8: sticky flag holds once set
   assert_sticky_hold_R8: assert property (@(posedge tck) disable iff (!dev_rst_n)
      test_sticky |=> test_sticky);

   // R8: pin drive implies sticky
   assert_sticky_set_R8: assert property (@(posedge tck) disable iff (!dev_rst_n)
      bsr_mode |-> test_sticky);

   // R9: at most one chain strobe, only when the chain is selected
   assert_strobe_onehot_R9: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({bsr_capture, bsr_shift, bsr_update}));
   assert_strobe_sel_R9: assert property (@(posedge tck) disable iff (!trst_n)
      (bsr_capture | bsr_shift | bsr_update) |-> bsr_sel);

   // R2: staying in reset leaves the identify instruction active
   assert_reset_ident_R2: assert property (@(posedge tck) disable iff (!trst_n)
      (fsm_state == ST_RESET && $past(fsm_state) == ST_RESET) |-> ir_active == OP_IDENT);

endmodule

bind jtag_tap_port jtag_tap_port_chk u_chk (
   .tck         (tck),
   .trst_n      (trst_n),
   .dev_rst_n   (dev_rst_n),
   .fsm_state   (fsm_state),
   .ir_active   (ir_active),
   .tdo_en      (tdo_en),
   .out_float   (out_float),
   .bsr_mode    (bsr_mode),
   .test_sticky (test_sticky),
   .bsr_sel     (bsr_sel),
   .bsr_capture (bsr_capture),
   .bsr_shift   (bsr_shift),
   .bsr_update  (bsr_update)
);

// File: tb/sim_jtag_tap_port.sv
`timescale 1ns/1ps
module sim_jtag_tap_port;

   localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_HDR = 4, S_E1D = 5,
                  S_PDR = 6, S_E2D = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_HIR = 11,
                  S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;
   localparam logic [31:0] EXP_ID = {4'hA, 16'h05D0, 11'h001, 1'b1};

   logic tck = 1'b0;
   logic tms = 1'b1, tdi = 1'b1, trst_n = 1'b0, dev_rst_n = 1'b0;
   logic bsr_tdo;
   logic tdo, tdo_en, bsr_sel, bsr_capture, bsr_shift, bsr_update, bsr_mode, out_float, test_sticky;

   int n_tests = 0, n_fail = 0;

   always #10 tck = ~tck;

   jtag_tap_port #(.VERSION(4'hA), .HAS_TRST(1'b1)) u0 (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .dev_rst_n(dev_rst_n),
      .bsr_tdo(bsr_tdo), .tdo(tdo), .tdo_en(tdo_en), .bsr_sel(bsr_sel),
      .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
      .bsr_mode(bsr_mode), .out_float(out_float), .test_sticky(test_sticky));

   // external chain model
   logic [7:0] pins = 8'hC5, chain = 8'h00, chain_upd = 8'h00;
   always @(posedge tck) begin
      if (bsr_capture)     chain <= pins;
      else if (bsr_shift)  chain <= {tdi, chain[7:1]};
      if (bsr_update)      chain_upd <= chain;
   end
   assign bsr_tdo = chain[0];

   // reference model
   int         m_st = S_TLR;
   logic [4:0] m_ir = 5'b00001, m_act = 5'b00010;
   logic       m_byp = 1'b0, m_tdo = 1'b0, m_en = 1'b0, m_sticky = 1'b0;
   logic [31:0] m_id = EXP_ID;

   function automatic int nxt(input int s, input logic t);
      case (s)
         S_TLR: return t ? S_TLR : S_RTI;
         S_RTI, S_UDR, S_UIR: return t ? S_SDR : S_RTI;
         S_SDR: return t ? S_SIR : S_CDR;
         S_SIR: return t ? S_TLR : S_CIR;
         S_CDR, S_HDR: return t ? S_E1D : S_HDR;
         S_CIR, S_HIR: return t ? S_E1I : S_HIR;
         S_E1D: return t ? S_UDR : S_PDR;
         S_E1I: return t ? S_UIR : S_PIR;
         S_PDR: return t ? S_E2D : S_PDR;
         S_PIR: return t ? S_E2I : S_PIR;
         S_E2D: return t ? S_UDR : S_HDR;
         S_E2I: return t ? S_UIR : S_HIR;
         default: return S_TLR;
      endcase
   endfunction

   always @(posedge tck) begin
      if (trst_n) begin
         if (m_st == S_CIR) m_ir = 5'b00001;
         else if (m_st == S_HIR) m_ir = {tdi, m_ir[4:1]};
         else if (m_st == S_CDR) begin m_byp = 1'b0; m_id = EXP_ID; end
         else if (m_st == S_HDR) begin m_byp = tdi; m_id = {tdi, m_id[31:1]}; end
         m_st = nxt(m_st, tms);
      end
   end

   always @(negedge tck) begin
      if (trst_n) begin
         if (m_st == S_UIR) m_act = m_ir;
         if (m_st == S_TLR) m_act = 5'b00010;
         m_en = (m_st == S_HIR) || (m_st == S_HDR);
         if (m_st == S_HIR) m_tdo = m_ir[0];
         else if (m_st == S_HDR)
            m_tdo = (m_act <= 5'd1) ? bsr_tdo : (m_act == 5'd2) ? m_id[0] : m_byp;
      end
      if (m_act == 5'd0 && dev_rst_n) m_sticky = 1'b1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic cmp();
      logic sel;
      sel = (m_act <= 5'd1);
      chk("R10 tdo_en", {31'b0, tdo_en}, {31'b0, m_en});
      chk("R10 tdo", {31'b0, tdo}, {31'b0, m_tdo});
      chk("R4 bsr_sel", {31'b0, bsr_sel}, {31'b0, sel});
      chk("R9 bsr_capture", {31'b0, bsr_capture}, {31'b0, sel && m_st == S_CDR});
      chk("R9 bsr_shift", {31'b0, bsr_shift}, {31'b0, sel && m_st == S_HDR});
      chk("R9 bsr_update", {31'b0, bsr_update}, {31'b0, sel && m_st == S_UDR});
      chk("R8 bsr_mode", {31'b0, bsr_mode}, {31'b0, m_act == 5'd0});
      chk("R7 out_float", {31'b0, out_float}, {31'b0, m_act == 5'd3});
      chk("R8 test_sticky", {31'b0, test_sticky}, {31'b0, m_sticky});
   endtask

   task automatic step(input logic t, input logic d);
      tms = t; tdi = d;
      @(negedge tck); #3;
      cmp();
   endtask

   task automatic shift_dr(input int n, input logic [31:0] din, input int pause_at,
                           output logic [31:0] dout);
      dout = '0;
      step(1, 1); step(0, 1); step(0, 1);
      for (int i = 0; i < n; i++) begin
         dout[i] = tdo;
         if (i == pause_at && i != n - 1) begin
            step(1, din[i]); step(0, 1); step(0, 1); step(1, 1); step(0, 1);
         end else begin
            step(i == n - 1, din[i]);
         end
      end
      step(1, 1); step(0, 1);
   endtask

   task automatic shift_ir(input logic [4:0] code, output logic [4:0] dout);
      dout = '0;
      step(1, 1); step(1, 1); step(0, 1); step(0, 1);
      for (int i = 0; i < 5; i++) begin
         dout[i] = tdo;
         step(i == 4, code[i]);
      end
      step(1, 1); step(0, 1);
   endtask

   task automatic tap_hw_reset();
      trst_n = 1'b0;
      m_st = S_TLR; m_act = 5'b00010; m_en = 1'b0; m_tdo = 1'b0;
      @(negedge tck); #3;
      chk("R2 tdo_en in reset", {31'b0, tdo_en}, 32'd0);
      chk("R2 out_float in reset", {31'b0, out_float}, 32'd0);
      chk("R2 bsr_mode in reset", {31'b0, bsr_mode}, 32'd0);
      trst_n = 1'b1;
      step(0, 1);
   endtask

   initial begin : watchdog
      #3_000_000;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      logic [31:0] d32;
      logic [4:0]  d5;
      repeat (2) @(negedge tck);
      #3;
      chk("R2 reset tdo_en", {31'b0, tdo_en}, 32'd0);
      chk("R2 reset bsr_mode", {31'b0, bsr_mode}, 32'd0);
      chk("R2 reset out_float", {31'b0, out_float}, 32'd0);
      chk("R8 reset sticky", {31'b0, test_sticky}, 32'd0);
      dev_rst_n = 1'b1; trst_n = 1'b1;
      step(0, 1);

      // default instruction after reset reads the identification word
      shift_dr(32, 32'h0, 99, d32);
      chk("R5 R2 id readout", d32, EXP_ID);

      // capture pattern and sample/preload
      shift_ir(5'b00001, d5);
      chk("R3 ir capture", {27'b0, d5}, 32'h1);
      pins = 8'hC5;
      shift_dr(8, 32'h3C, 99, d32);
      chk("R9 sample capture", d32, 32'hC5);
      chk("R9 preload update", {24'b0, chain_upd}, 32'h3C);
      chk("R9 no pin drive", {31'b0, bsr_mode}, 32'd0);

      // bypass
      shift_ir(5'b11111, d5);
      chk("R3 ir capture again", {27'b0, d5}, 32'h1);
      shift_dr(8, 32'hA6, 3, d32);
      chk("R6 bypass delay", d32, 32'h4C);
      chk("R6 chain untouched", {24'b0, chain_upd}, 32'h3C);

      // undefined code behaves as bypass
      shift_ir(5'b10101, d5);
      shift_dr(8, 32'h59, 99, d32);
      chk("R4 undefined bypass", d32, 32'hB2);
      chk("R4 undefined no float", {31'b0, out_float}, 32'd0);

      // float instruction
      shift_ir(5'b00011, d5);
      chk("R7 float on", {31'b0, out_float}, 32'd1);
      shift_dr(4, 32'hF, 99, d32);
      chk("R4 float path bypass", d32, 32'hE);
      shift_ir(5'b11111, d5);
      chk("R7 float off", {31'b0, out_float}, 32'd0);

      // pin drive and sticky flag
      pins = 8'h96;
      shift_ir(5'b00000, d5);
      chk("R8 pin drive on", {31'b0, bsr_mode}, 32'd1);
      chk("R8 sticky set", {31'b0, test_sticky}, 32'd1);
      shift_dr(8, 32'h11, 99, d32);
      chk("R9 chain readout", d32, 32'h96);
      shift_ir(5'b11111, d5);
      chk("R8 pin drive off", {31'b0, bsr_mode}, 32'd0);
      chk("R8 sticky after change", {31'b0, test_sticky}, 32'd1);

      // five TMS-high edges from inside Shift-DR
      step(1, 1); step(0, 1); step(0, 1);
      repeat (5) step(1, 1);
      step(0, 1);
      shift_dr(32, 32'h0, 10, d32);
      chk("R1 tms reset then id", d32, EXP_ID);
      chk("R8 sticky after tap reset", {31'b0, test_sticky}, 32'd1);

      // device reset clears sticky
      dev_rst_n = 1'b0; m_sticky = 1'b0;
      @(negedge tck); #3;
      dev_rst_n = 1'b1;
      step(0, 1);
      chk("R8 sticky cleared", {31'b0, test_sticky}, 32'd0);

      // open TDI (all ones) then async reset mid-operation
      shift_ir(5'b11111, d5);
      step(1, 1); step(0, 1); step(0, 1);
      tap_hw_reset();
      shift_dr(32, 32'h0, 99, d32);
      chk("R2 id after trst", d32, EXP_ID);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule